// File: doc/BRIEF.md
# Receive Character Queue with Stale-Data Watchdog and Flow Control

This block sits between a serial receiver's shift register and the host. Every completed character arrives on a one-cycle strobe with its eight data bits and three error marks (line break seen, bad stop bit, bad parity). Up to sixteen characters are kept in arrival order. The oldest one is always presented at the read port. The host takes it by pulsing the read strobe.

A two-bit level select sets the occupancy at which the receive interrupt rises. A watchdog counts bit-time ticks while characters sit in the queue and nothing moves. It reports data that has gone stale, which catches a message tail too short to reach the interrupt level. When the queue is full, one more character can wait in a single holding slot. Any further arrival while that slot is occupied is an overrun: the held character is replaced and a sticky flag is set. With automatic flow control enabled, the request-to-send output drops while the queue is full.

Two state machines do the sequencing. The holding slot has the states `H_EMPTY` (no waiting character) and `H_WAIT` (one character waiting). Its transitions are:
- direct store: an arrival while there is room;
- park: an arrival while the queue is full;
- drain: a read frees room while a character waits;
- replace: an arrival while a character waits and there is no room.

The watchdog has the states `W_IDLE` (queue empty), `W_COUNT` (timing) and `W_FIRED` (stale flag set). Its transitions are:
- restart: any load or read, which leads to `W_COUNT`;
- empty: the queue runs dry, which leads to `W_IDLE`;
- expire: the 64th tick arrives with no restart, which leads to `W_FIRED`.

Top module: `rxq_guard`

## Requirements
- R1: After reset, the block shows `fill`=0, `rx_irq`=0, `stale`=0, `overrun`=0 and `rts_on`=1.
- R2: Characters are read back in arrival order, each with its own break, framing and parity marks. The oldest entry is shown at the read port without a read. A read with a non-empty queue removes that entry at the next clock edge.
- R3: `rx_irq` is 1 when `fill` is at least the threshold chosen by `lvl_sel`, and 0 otherwise. The thresholds are: `00` gives 1, `01` gives 8, `10` gives 12, `11` gives 16.
- R4: A character arrival and a read in the same cycle leave `fill` unchanged.
- R5: An arrival while 16 entries are held does not change `fill`. That character waits, and it enters the queue in the cycle of the next read, so `fill` stays 16 and arrival order is kept.
- R6: An arrival while the queue is full and a character is already waiting sets `overrun`. The waiting character is replaced by the newest one, and the 16 queued entries are left untouched.
- R7: `overrun` stays 1 through later reads and arrivals until `err_clr` is pulsed. After the pulse it reads 0.
- R8: `stale` rises after 64 `tick` pulses with a non-empty queue and no load or read in between. It is still 0 after 63 such pulses.
- R9: Any load or read restarts the 64-tick count and clears `stale` at the next clock edge. Ticks do not count while the queue is empty.
- R10: With `rts_auto_en`=1, `rts_on` is 0 while `fill`=16 and 1 as soon as `fill` is below 16. With `rts_auto_en`=0, `rts_on` stays 1.
- R11: A read with an empty queue has no effect. `fill` stays 0, and the next arrival appears at the read port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chr_vld | input | 1 | One-cycle strobe: a character is complete |
| chr_data | input | 8 | Received character |
| chr_brk | input | 1 | Break mark of the arriving character |
| chr_frm | input | 1 | Framing-error mark of the arriving character |
| chr_par | input | 1 | Parity-error mark of the arriving character |
| rd_en | input | 1 | Host read strobe; takes the oldest entry |
| tick | input | 1 | One pulse per bit time |
| lvl_sel | input | 2 | Interrupt threshold select |
| rts_auto_en | input | 1 | Enables automatic flow control |
| err_clr | input | 1 | Clears the overrun flag |
| rd_data | output | 8 | Oldest queued character |
| rd_brk | output | 1 | Break mark of the oldest entry |
| rd_frm | output | 1 | Framing mark of the oldest entry |
| rd_par | output | 1 | Parity mark of the oldest entry |
| fill | output | 5 | Number of queued entries, 0 to 16 |
| rx_irq | output | 1 | Occupancy at or above the threshold |
| stale | output | 1 | Watchdog expired |
| overrun | output | 1 | Sticky overrun flag |
| rts_on | output | 1 | Request-to-send, 1 = asserted |

## Verification
The bench pushes the queue to full and beyond, then reads it out. A design that dropped the parked character, or counted it into `fill`, shows a wrong sequence or a count of 17. Repeated arrivals while a character waits must leave exactly the newest one behind. A design that overwrote queue storage or kept the older waiting character returns wrong data. The watchdog is probed at 63 and 64 ticks, across a restart caused by a second load, and with an empty queue, which catches off-by-one limits, missed restarts and counting while empty. Same-cycle arrival and read, a read of an empty queue, each threshold edge, and flow-control release on the first freed slot are each checked at the ports.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int CHAR_W = 8;

    typedef struct packed {
        logic              brk;
        logic              frm;
        logic              par;
        logic [CHAR_W-1:0] data;
    } rxq_char_t;

    typedef enum logic {
        H_EMPTY = 1'b0,
        H_WAIT  = 1'b1
    } hold_st_e;

    typedef enum logic [1:0] {
        W_IDLE  = 2'd0,
        W_COUNT = 2'd1,
        W_FIRED = 2'd2
    } wd_st_e;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  rxq_char_t        push_char,
    input  logic             pop,
    output rxq_char_t        head_char,
    output logic [CNT_W-1:0] level
);
    rxq_char_t        mem [DEPTH];
    logic [PTR_W-1:0] wptr;
    logic [PTR_W-1:0] rptr;

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wptr] <= push_char;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (push) wptr <= wptr + 1'b1;
            if (pop)  rptr <= rptr + 1'b1;
            unique case ({push, pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    assign head_char = mem[rptr];

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CNT_W'(DEPTH));

    // R4
    pushpop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop) |=> (level == $past(level)));
endmodule

// File: rtl/rxq_hold.sv
module rxq_hold
    import rxq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      chr_vld,
    input  rxq_char_t chr_in,
    input  logic      full,
    input  logic      pop,
    input  logic      err_clr,
    output logic      push,
    output rxq_char_t push_char,
    output logic      ovr
);
    hold_st_e  st_q, st_d;
    rxq_char_t slot_q;
    logic      load_slot;
    logic      ovr_set;
    logic      room;

    assign room = !full || pop;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= H_EMPTY;
            slot_q <= '0;
            ovr    <= 1'b0;
        end else begin
            st_q <= st_d;
            if (load_slot) slot_q <= chr_in;
            if (ovr_set)      ovr <= 1'b1;
            else if (err_clr) ovr <= 1'b0;
        end
    end

    always_comb begin
        st_d      = st_q;
        push      = 1'b0;
        push_char = chr_in;
        load_slot = 1'b0;
        ovr_set   = 1'b0;
        unique case (st_q)
            H_EMPTY: begin
                if (chr_vld) begin
                    if (room) begin
                        push = 1'b1;
                    end else begin
                        load_slot = 1'b1;
                        st_d      = H_WAIT;
                    end
                end
            end
            H_WAIT: begin
                if (room) begin
                    push      = 1'b1;
                    push_char = slot_q;
                    if (chr_vld) load_slot = 1'b1;
                    else         st_d      = H_EMPTY;
                end else if (chr_vld) begin
                    load_slot = 1'b1;
                    ovr_set   = 1'b1;
                end
            end
            default: st_d = H_EMPTY;
        endcase
    end

    // R6
    ovr_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !$past(ovr)) |-> $past(full));
endmodule

// File: rtl/rxq_wdog.sv
module rxq_wdog
    import rxq_pkg::*;
#(
    parameter int LIMIT = 64,
    localparam int TC_W = $clog2(LIMIT)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic restart,
    input  logic nonempty,
    output logic fired
);
    wd_st_e          st_q, st_d;
    logic [TC_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= W_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (restart) begin
            st_d  = W_COUNT;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                W_IDLE: begin
                    cnt_d = '0;
                end
                W_COUNT: begin
                    if (!nonempty) begin
                        st_d = W_IDLE;
                    end else if (tick) begin
                        if (cnt_q == TC_W'(LIMIT - 1)) st_d = W_FIRED;
                        else cnt_d = cnt_q + 1'b1;
                    end
                end
                W_FIRED: begin
                    if (!nonempty) st_d = W_IDLE;
                end
                default: st_d = W_IDLE;
            endcase
        end
    end

    always_comb begin
        fired = (st_q == W_FIRED);
    end

    // R8
    stale_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fired |-> nonempty);
endmodule

// File: rtl/rxq_guard.sv
module rxq_guard
    import rxq_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int WD_TICKS = 64,
    localparam int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chr_vld,
    input  logic [7:0]       chr_data,
    input  logic             chr_brk,
    input  logic             chr_frm,
    input  logic             chr_par,
    input  logic             rd_en,
    input  logic             tick,
    input  logic [1:0]       lvl_sel,
    input  logic             rts_auto_en,
    input  logic             err_clr,
    output logic [7:0]       rd_data,
    output logic             rd_brk,
    output logic             rd_frm,
    output logic             rd_par,
    output logic [CNT_W-1:0] fill,
    output logic             rx_irq,
    output logic             stale,
    output logic             overrun,
    output logic             rts_on
);
    localparam logic [CNT_W-1:0] THR_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] THR_HALF = CNT_W'(DEPTH / 2);
    localparam logic [CNT_W-1:0] THR_3Q   = CNT_W'((3 * DEPTH) / 4);
    localparam logic [CNT_W-1:0] THR_FULL = CNT_W'(DEPTH);

    rxq_char_t        in_char, push_char, head_char;
    logic             push, pop, full;
    logic [CNT_W-1:0] level, thr;

    assign in_char = '{brk: chr_brk, frm: chr_frm, par: chr_par, data: chr_data};
    assign full    = (level == THR_FULL);
    assign pop     = rd_en && (level != '0);

    rxq_hold u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .chr_vld   (chr_vld),
        .chr_in    (in_char),
        .full      (full),
        .pop       (pop),
        .err_clr   (err_clr),
        .push      (push),
        .push_char (push_char),
        .ovr       (overrun)
    );

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_char (push_char),
        .pop       (pop),
        .head_char (head_char),
        .level     (level)
    );

    rxq_wdog #(.LIMIT(WD_TICKS)) u_wdog (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .restart  (push || pop),
        .nonempty (level != '0),
        .fired    (stale)
    );

    always_comb begin
        unique case (lvl_sel)
            2'b00:   thr = THR_ONE;
            2'b01:   thr = THR_HALF;
            2'b10:   thr = THR_3Q;
            default: thr = THR_FULL;
        endcase
    end

    assign fill    = level;
    assign rx_irq  = (level >= thr);
    assign rts_on  = !(rts_auto_en && full);
    assign rd_data = head_char.data;
    assign rd_brk  = head_char.brk;
    assign rd_frm  = head_char.frm;
    assign rd_par  = head_char.par;

    // R10
    rts_vs_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rts_auto_en && lvl_sel == 2'b11) |-> (rts_on != rx_irq));
endmodule

// File: tb/rxq_guard_bench.sv
module rxq_guard_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chr_vld = 1'b0, chr_brk = 1'b0, chr_frm = 1'b0, chr_par = 1'b0;
    logic [7:0] chr_data = '0;
    logic       rd_en = 1'b0, tick = 1'b0, rts_auto_en = 1'b0, err_clr = 1'b0;
    logic [1:0] lvl_sel = 2'b00;
    logic [7:0] rd_data;
    logic       rd_brk, rd_frm, rd_par, rx_irq, stale, overrun, rts_on;
    logic [4:0] fill;
    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    rxq_guard u_rxq_guard (
        .clk(clk), .rst_n(rst_n), .chr_vld(chr_vld), .chr_data(chr_data),
        .chr_brk(chr_brk), .chr_frm(chr_frm), .chr_par(chr_par),
        .rd_en(rd_en), .tick(tick), .lvl_sel(lvl_sel),
        .rts_auto_en(rts_auto_en), .err_clr(err_clr),
        .rd_data(rd_data), .rd_brk(rd_brk), .rd_frm(rd_frm), .rd_par(rd_par),
        .fill(fill), .rx_irq(rx_irq), .stale(stale), .overrun(overrun),
        .rts_on(rts_on)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        chr_vld = 0; rd_en = 0; tick = 0; err_clr = 0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic push_chr(input logic [7:0] d, input logic [2:0] fl);
        chr_vld = 1'b1; chr_data = d; {chr_brk, chr_frm, chr_par} = fl;
        @(negedge clk);
        chr_vld = 1'b0;
    endtask

    task automatic pop_chk(input string req, input int exp_d);
        check(req, rd_data, exp_d);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 fill", fill, 0);
        check("R1 irq", rx_irq, 0);
        check("R1 stale", stale, 0);
        check("R1 overrun", overrun, 0);
        check("R1 rts", rts_on, 1);
    endtask

    task automatic t_order();
        do_reset();
        push_chr(8'hA1, 3'b100);
        push_chr(8'h5B, 3'b010);
        push_chr(8'hC3, 3'b001);
        check("R2 fill", fill, 3);
        check("R2 brk", rd_brk, 1);
        pop_chk("R2 data0", 8'hA1);
        check("R2 frm", rd_frm, 1);
        check("R2 fill after read", fill, 2);
        pop_chk("R2 data1", 8'h5B);
        check("R2 par", rd_par, 1);
        pop_chk("R2 data2", 8'hC3);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check("R11 empty read fill", fill, 0);
        push_chr(8'h3E, 3'b000);
        check("R11 next arrival", rd_data, 8'h3E);
        check("R11 fill", fill, 1);
    endtask

    task automatic t_same_cycle();
        do_reset();
        push_chr(8'h11, 3'b000);
        push_chr(8'h22, 3'b000);
        chr_vld = 1'b1; chr_data = 8'h33; rd_en = 1'b1;
        @(negedge clk);
        chr_vld = 1'b0; rd_en = 1'b0;
        check("R4 fill", fill, 2);
        pop_chk("R4 head", 8'h22);
        pop_chk("R4 tail", 8'h33);
    endtask

    task automatic t_levels();
        int thr [4] = '{1, 8, 12, 16};
        for (int s = 0; s < 4; s++) begin
            do_reset();
            lvl_sel = 2'(s);
            for (int i = 0; i < thr[s] - 1; i++) push_chr(8'(i), 3'b000);
            check("R3 below threshold", rx_irq, 0);
            push_chr(8'hFF, 3'b000);
            check("R3 at threshold", rx_irq, 1);
        end
        lvl_sel = 2'b00;
    endtask

    task automatic t_full();
        do_reset();
        rts_auto_en = 1'b1;
        for (int i = 0; i < 15; i++) push_chr(8'(i), 3'b000);
        check("R10 rts at 15", rts_on, 1);
        push_chr(8'd15, 3'b000);
        check("R10 rts at 16", rts_on, 0);
        push_chr(8'd16, 3'b000);
        check("R5 fill with waiting char", fill, 16);
        check("R5 no overrun", overrun, 0);
        pop_chk("R5 first", 0);
        check("R5 drain keeps fill", fill, 16);
        check("R10 rts still low", rts_on, 0);
        pop_chk("R5 second", 1);
        check("R10 rts released", rts_on, 1);
        for (int i = 2; i < 17; i++) pop_chk("R5 order", i);
        check("R5 empty", fill, 0);
        rts_auto_en = 1'b0;
        for (int i = 0; i < 16; i++) push_chr(8'(i), 3'b000);
        check("R10 disabled rts", rts_on, 1);
    endtask

    task automatic t_overrun();
        do_reset();
        for (int i = 0; i < 16; i++) push_chr(8'(i + 32), 3'b000);
        push_chr(8'd100, 3'b000);
        check("R6 no overrun yet", overrun, 0);
        push_chr(8'd101, 3'b000);
        check("R6 overrun set", overrun, 1);
        push_chr(8'd102, 3'b001);
        check("R6 fill", fill, 16);
        for (int i = 0; i < 16; i++) pop_chk("R6 queued untouched", i + 32);
        check("R6 newest kept", rd_data, 102);
        check("R6 newest flags", rd_par, 1);
        pop_chk("R6 newest", 102);
        check("R6 empty", fill, 0);
        check("R7 sticky", overrun, 1);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        check("R7 cleared", overrun, 0);
    endtask

    task automatic t_wdog();
        do_reset();
        push_chr(8'h44, 3'b000);
        ticks(63);
        check("R8 after 63", stale, 0);
        ticks(1);
        check("R8 after 64", stale, 1);
        pop_chk("R9 read data", 8'h44);
        check("R9 cleared by read", stale, 0);
        ticks(70);
        check("R9 empty no count", stale, 0);
        push_chr(8'h45, 3'b000);
        ticks(40);
        push_chr(8'h46, 3'b000);
        ticks(40);
        check("R9 load restarts", stale, 0);
        ticks(24);
        check("R8 fires after restart", stale, 1);
        push_chr(8'h47, 3'b000);
        check("R9 cleared by load", stale, 0);
    endtask

    initial begin
        t_reset();
        t_order();
        t_same_cycle();
        t_levels();
        t_full();
        t_overrun();
        t_wdog();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule